// File: doc/BRIEF.md
# Prefix Real-to-Absolute Address Remapper

This block turns a real address into an absolute address under a per-processor prefix. Two 8 KB regions trade places: the region at address zero and the region that begins at the prefix value. A real address that falls in the zero region is moved up by the prefix. A real address that falls in the prefix region is moved down to zero. Any address outside both regions comes through unchanged.

The mapping sits after address translation. It is used whether translation produced the real address or translation was switched off and the address was taken as real already. The prefix is treated as 8 KB aligned: its low 13 bits are ignored. A valid strobe travels with the address. By default an output register adds one cycle of latency. A parameter removes that register for a purely combinational path.

Top module: `prefix_remap`

## Requirements
- R1: A valid real address below 0x2000 produces an absolute address equal to that address plus the aligned prefix.
- R2: A valid real address that is at or above the aligned prefix and below the aligned prefix plus 0x2000 produces that address minus the aligned prefix.
- R3: A valid real address in neither region produces the same address unchanged, including 0x2000 and the addresses just outside both ends of the prefix region.
- R4: Bits 12 down to 0 of the prefix have no effect on the result: prefixes that differ only in those bits give identical absolute addresses.
- R5: With an aligned prefix of zero, every address passes through unchanged, including addresses below 0x2000.
- R6: With the output register enabled (OUT_REG=1), abs_vld_o is high in exactly those cycles that follow a cycle with real_vld_i high. The matching result is on abs_addr_o in the same cycle.
- R7: While rst is high, abs_vld_o and abs_addr_o read as zero at the clock edge, whatever the inputs are.
- R8: With the output register enabled, abs_addr_o keeps its last value in the cycles after real_vld_i is low, even when real_addr_i and prefix_i change.
- R9: When the prefix is 0x2000, the two regions are adjacent. 0x0000-0x1FFF maps to 0x2000-0x3FFF, 0x2000-0x3FFF maps to 0x0000-0x1FFF, and 0x4000 passes through.
- R10: When the prefix region is the topmost 8 KB of the address space, addresses in that region map to the zero region, and the upper bound does not wrap around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| real_vld_i | input | 1 | Real address is valid this cycle |
| real_addr_i | input | ADDR_W | Real address to be mapped |
| prefix_i | input | ADDR_W | Prefix value; low WIN_BITS bits are ignored |
| abs_vld_o | output | 1 | Absolute address is valid |
| abs_addr_o | output | ADDR_W | Absolute address |

## Verification
The hardest cases to reach are the prefix-region boundaries when the prefix sits at the top of the address space, where the region end cannot be expressed without overflow. Equally hard is the adjacent-region case, where a single address step moves from one swap direction to the other. The stimulus programs those prefixes on purpose and probes the first and last byte of each region plus the byte on either side. Between vectors it also lets real_vld_i drop while the address and prefix keep changing, to show that the held output does not move.

// File: rtl/prefix_map_pkg.sv
package prefix_map_pkg;

  // Which of the two swapped regions an address falls into.
  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_LOW  = 2'd1,
    WIN_PFX  = 2'd2
  } win_sel_e;

endpackage

// File: rtl/pfx_window_detect.sv
module pfx_window_detect
  import prefix_map_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int WIN_BITS = 13
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] pfx_i,
  output win_sel_e          sel_o
);
  localparam int HI_W = ADDR_W - WIN_BITS;

  logic [HI_W-1:0] addr_hi;
  logic [HI_W-1:0] pfx_hi;
  logic            low_hit;
  logic            pfx_hit;

  // Only the upper bits take part: the prefix is treated as aligned, and
  // an equal upper part means base <= addr < base + span, with no overflow.
  assign addr_hi = addr_i[ADDR_W-1:WIN_BITS];
  assign pfx_hi  = pfx_i[ADDR_W-1:WIN_BITS];
  assign low_hit = (addr_hi == '0);
  assign pfx_hit = (addr_hi == pfx_hi);

  // The low region wins; with a zero prefix both cases give the same result.
  always_comb begin
    if (low_hit)      sel_o = WIN_LOW;
    else if (pfx_hit) sel_o = WIN_PFX;
    else              sel_o = WIN_NONE;
  end

  logic unused_pfx_lo;
  assign unused_pfx_lo = ^pfx_i[WIN_BITS-1:0];
endmodule

// File: rtl/pfx_addr_build.sv
module pfx_addr_build
  import prefix_map_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int WIN_BITS = 13
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] pfx_i,
  input  win_sel_e          sel_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int HI_W = ADDR_W - WIN_BITS;

  logic [WIN_BITS-1:0] offs;
  assign offs = addr_i[WIN_BITS-1:0];

  // With an aligned base and an offset that stays inside the region, adding
  // and subtracting the base come down to replacing the upper bits.
  always_comb begin
    unique case (sel_i)
      WIN_LOW: addr_o = {pfx_i[ADDR_W-1:WIN_BITS], offs};
      WIN_PFX: addr_o = {{HI_W{1'b0}}, offs};
      default: addr_o = addr_i;
    endcase
  end

  logic unused_pfx_lo;
  assign unused_pfx_lo = ^pfx_i[WIN_BITS-1:0];
endmodule

// File: rtl/pfx_out_stage.sv
module pfx_out_stage #(
  parameter int DATA_W  = 64,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] data_o
);
  generate
    if (OUT_REG) begin : g_reg
      logic              vld_q;
      logic [DATA_W-1:0] data_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          vld_q  <= 1'b0;
          data_q <= '0;
        end else begin
          vld_q <= vld_i;
          if (vld_i) data_q <= data_i;
        end
      end

      assign vld_o  = vld_q;
      assign data_o = data_q;
    end else begin : g_bypass
      assign vld_o  = vld_i;
      assign data_o = data_i;

      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst;
    end
  endgenerate
endmodule

// File: rtl/prefix_remap.sv
module prefix_remap
  import prefix_map_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int WIN_BITS = 13,
  parameter bit OUT_REG  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              real_vld_i,
  input  logic [ADDR_W-1:0] real_addr_i,
  input  logic [ADDR_W-1:0] prefix_i,
  output logic              abs_vld_o,
  output logic [ADDR_W-1:0] abs_addr_o
);
  localparam logic [ADDR_W-1:0] WIN_SPAN = ADDR_W'(1) << WIN_BITS;
  localparam logic [ADDR_W-1:0] LO_MASK  = WIN_SPAN - ADDR_W'(1);

  win_sel_e          sel;
  logic [ADDR_W-1:0] mapped;
  logic [ADDR_W-1:0] pfx_al;

  assign pfx_al = prefix_i & ~LO_MASK;

  pfx_window_detect #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) i_detect (
    .addr_i (real_addr_i),
    .pfx_i  (prefix_i),
    .sel_o  (sel)
  );

  pfx_addr_build #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) i_build (
    .addr_i (real_addr_i),
    .pfx_i  (prefix_i),
    .sel_i  (sel),
    .addr_o (mapped)
  );

  pfx_out_stage #(.DATA_W(ADDR_W), .OUT_REG(OUT_REG)) i_out (
    .clk    (clk),
    .rst    (rst),
    .vld_i  (real_vld_i),
    .data_i (mapped),
    .vld_o  (abs_vld_o),
    .data_o (abs_addr_o)
  );

  generate
    if (OUT_REG) begin : g_chk
      AST_LOW_WIN: assert property (@(posedge clk) disable iff (rst)
        (real_vld_i && real_addr_i < WIN_SPAN) |=>
          abs_addr_o == $past(real_addr_i) + $past(pfx_al)); // R1
      AST_PFX_WIN: assert property (@(posedge clk) disable iff (rst)
        (real_vld_i && pfx_al != '0 && real_addr_i >= pfx_al &&
         (real_addr_i - pfx_al) < WIN_SPAN) |=>
          abs_addr_o == $past(real_addr_i) - $past(pfx_al)); // R2
      AST_PASS_THRU: assert property (@(posedge clk) disable iff (rst)
        (real_vld_i && real_addr_i >= WIN_SPAN &&
         (real_addr_i < pfx_al || (real_addr_i - pfx_al) >= WIN_SPAN)) |=>
          abs_addr_o == $past(real_addr_i)); // R3
      AST_VLD_LAT: assert property (@(posedge clk) disable iff (rst)
        real_vld_i |=> abs_vld_o); // R6
      AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !real_vld_i |=> !abs_vld_o); // R6
      AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !real_vld_i |=> $stable(abs_addr_o)); // R8
    end
  endgenerate
endmodule

// File: tb/test_prefix_remap.sv
`timescale 1ns/1ps
module test_prefix_remap;
  localparam int AW = 64;

  logic          clk = 1'b0;
  logic          rst;
  logic          real_vld_i;
  logic [AW-1:0] real_addr_i;
  logic [AW-1:0] prefix_i;
  logic          abs_vld_o;
  logic [AW-1:0] abs_addr_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [AW-1:0] exp_q[$];
  string         tag_q[$];
  logic [AW-1:0] last_exp = '0;
  logic          exp_vld_q = 1'b0;

  always #4 clk = ~clk;

  prefix_remap i_prefix_remap (
    .clk(clk), .rst(rst), .real_vld_i(real_vld_i), .real_addr_i(real_addr_i),
    .prefix_i(prefix_i), .abs_vld_o(abs_vld_o), .abs_addr_o(abs_addr_o)
  );

  function automatic logic [AW-1:0] ref_map(logic [AW-1:0] a, logic [AW-1:0] p);
    logic [AW-1:0] pm;
    pm = p & ~64'h1FFF;
    if (a < 64'h2000) return a + pm;
    if (a >= pm && (a - pm) < 64'h2000) return a - pm;
    return a;
  endfunction

  task automatic check(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(string tag, logic [AW-1:0] a, logic [AW-1:0] p);
    @(negedge clk);
    real_vld_i  = 1'b1;
    real_addr_i = a;
    prefix_i    = p;
    exp_q.push_back(ref_map(a, p));
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      real_vld_i  = 1'b0;
      real_addr_i = real_addr_i + 64'h1234_5000;
      prefix_i    = prefix_i ^ 64'h0000_0100_0000_6000;
    end
  endtask

  // Bench-side model of the one-cycle valid latency
  always @(posedge clk) exp_vld_q <= rst ? 1'b0 : real_vld_i;

  // Monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (!rst && !done) begin
        check("R6 vld", {63'd0, abs_vld_o}, {63'd0, exp_vld_q});
        if (abs_vld_o) begin
          if (exp_q.size() == 0) begin
            check("R6 unexpected result", 64'd1, 64'd0);
          end else begin
            logic [AW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, abs_addr_o, e);
            last_exp = e;
          end
        end else begin
          check("R8 hold", abs_addr_o, last_exp);
        end
      end
    end
  end

  // Watchdog
  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    real_vld_i = 1'b1;
    real_addr_i = 64'h10;
    prefix_i = 64'h4000;
    repeat (3) @(posedge clk);
    #2;
    check("R7 vld in reset", {63'd0, abs_vld_o}, 64'd0);
    check("R7 addr in reset", abs_addr_o, 64'd0);
    @(negedge clk);
    real_vld_i = 1'b0;
    rst = 1'b0;
    idle(2);

    // R1/R2/R3 with prefix 0x34000
    drive("R1 low start",   64'h0,     64'h34000);
    drive("R1 low end",     64'h1FFF,  64'h34000);
    drive("R3 0x2000",      64'h2000,  64'h34000);
    drive("R2 pfx start",   64'h34000, 64'h34000);
    drive("R2 pfx end",     64'h35FFF, 64'h34000);
    drive("R3 above pfx",   64'h36000, 64'h34000);
    drive("R3 below pfx",   64'h33FFF, 64'h34000);
    drive("R3 far",         64'h1234_5678_9ABC_DEF0, 64'h34000);
    idle(3);

    // R4: unaligned prefix bits ignored
    drive("R4 low",  64'h10,     64'h35ABC);
    drive("R4 pfx",  64'h34010,  64'h35ABC);
    drive("R4 pass", 64'h36010,  64'h35FFF);
    idle(2);

    // R5: zero aligned prefix
    drive("R5 low",  64'h100,  64'h0);
    drive("R5 edge", 64'h1FFF, 64'h1FFF);
    drive("R5 mid",  64'h8000, 64'h0);
    idle(1);

    // R9: adjacent regions
    drive("R9 low",      64'h1000, 64'h2000);
    drive("R9 pfx lo",   64'h2000, 64'h2000);
    drive("R9 pfx hi",   64'h3FFF, 64'h2000);
    drive("R9 pass",     64'h4000, 64'h2000);
    idle(2);

    // R10: prefix region at top of address space
    drive("R10 top",     64'hFFFF_FFFF_FFFF_FFF0, 64'hFFFF_FFFF_FFFF_E000);
    drive("R10 base",    64'hFFFF_FFFF_FFFF_E000, 64'hFFFF_FFFF_FFFF_E000);
    drive("R10 below",   64'hFFFF_FFFF_FFFF_DFFF, 64'hFFFF_FFFF_FFFF_E000);
    drive("R10 low",     64'h5,                   64'hFFFF_FFFF_FFFF_E000);
    idle(4);

    check("R6 nothing pending", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule